// File: doc/BRIEF.md
# Register Rename Table with Producer Tags

This block is the architectural register file of an out-of-order core, widened so that each register also carries a pending flag and the tag of the reorder buffer slot that will produce its next value. Because a consumer learns that tag directly from the table, the reorder buffer can be read by index. It never has to be searched by register number.

Each cycle the decode stage performs two source lookups. Each lookup returns a ready flag, the stored value and the stored tag. In the same cycle the decode stage may rename one destination register to a new tag. The retire stage may commit one result per cycle. A commit always writes the value. It clears the pending flag only when the committing tag is still the register's most recent mapping. A flush, raised when an exception empties the pipeline, marks every register ready and drops all pending tags.

Lookups always see the table as it stood at the start of the cycle. Updates made in a cycle become visible in the next one. Register 0 is a constant zero and is never renamed.

Top module: `rename_table`

## Requirements
- R1: After reset, every register reads ready (1) with value 0.
- R2: Register 0 always reads ready with value 0. A rename or a commit that names register 0 has no effect.
- R3: After a rename of register r (r ≠ 0) to tag t without a flush, lookups of r return ready 0 and tag t from the next cycle on.
- R4: A lookup returns the state from before the current cycle's updates. A source that names the register being renamed in the same cycle sees its old mapping.
- R5: The two lookup ports are independent. Both return identical results when they name the same register.
- R6: A commit to a pending register whose stored tag equals the commit tag writes the value and makes the register ready in the next cycle.
- R7: A commit to a pending register whose stored tag differs writes the value, and the register stays pending with its newer tag. The value output always shows the stored value, whether the register is ready or not.
- R8: A commit to a register that is already ready writes the value, and the register stays ready.
- R9: A rename and a commit to the same register in the same cycle leave the register pending under the new tag, holding the committed value.
- R10: A flush makes every register ready in the next cycle and keeps the stored values. A rename in the flush cycle is discarded. A commit in the flush cycle still writes its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| flush_i | input | 1 | Drop all pending mappings |
| src_a_idx_i | input | 5 | Lookup A register index |
| src_a_ready_o | output | 1 | Lookup A: register value is current |
| src_a_value_o | output | 32 | Lookup A: stored value |
| src_a_tag_o | output | 5 | Lookup A: producer tag, meaningful when not ready |
| src_b_idx_i | input | 5 | Lookup B register index |
| src_b_ready_o | output | 1 | Lookup B: register value is current |
| src_b_value_o | output | 32 | Lookup B: stored value |
| src_b_tag_o | output | 5 | Lookup B: producer tag, meaningful when not ready |
| ren_en_i | input | 1 | Destination rename request |
| ren_reg_i | input | 5 | Register being renamed |
| ren_tag_i | input | 5 | New producer tag |
| com_en_i | input | 1 | Commit request |
| com_reg_i | input | 5 | Register being committed |
| com_tag_i | input | 5 | Tag of the committing producer |
| com_value_i | input | 32 | Committed value |

## Verification
The bench concentrates on the cases where two writers of one register overlap. One case is a register renamed twice, where the older producer commits first: a design that ignored the tag compare would mark the register ready too early, and a consumer would read a value that is no longer current. Another is a rename and a commit to one register in the same cycle: a design with the wrong priority would drop the new mapping and report the register ready. The bench also checks that a lookup in a renaming cycle still sees the old mapping, that register 0 ignores both writers, and that a flush clears pending state while keeping a same-cycle commit. A long random phase with frequent tag matches compares every lookup against a model written from the requirements.

// File: rtl/rt_pkg.sv
package rt_pkg;
    // Default geometry shared by the table and its sub-blocks
    localparam int DEF_NUM_REGS = 32;
    localparam int DEF_DATA_W   = 32;
    localparam int DEF_TAG_W    = 5;
endpackage

// File: rtl/rt_entry.sv
// One renamable register: stored value, ready flag and producer tag.
module rt_entry #(
    parameter int DATA_W = rt_pkg::DEF_DATA_W,
    parameter int TAG_W  = rt_pkg::DEF_TAG_W
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              flush_i,
    input  logic              ren_hit_i,
    input  logic [TAG_W-1:0]  ren_tag_i,
    input  logic              com_hit_i,
    input  logic [TAG_W-1:0]  com_tag_i,
    input  logic [DATA_W-1:0] com_value_i,
    output logic              valid_o,
    output logic [TAG_W-1:0]  tag_o,
    output logic [DATA_W-1:0] value_o
);
    typedef struct packed {
        logic              valid;
        logic [TAG_W-1:0]  tag;
        logic [DATA_W-1:0] value;
    } entry_t;

    entry_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // Retirement: value always lands; pending clears only on tag match
        if (com_hit_i) begin
            st_d.value = com_value_i;
            if (!st_q.valid && (st_q.tag == com_tag_i))
                st_d.valid = 1'b1;
        end
        // A new rename outranks a commit in the same cycle
        if (ren_hit_i) begin
            st_d.valid = 1'b0;
            st_d.tag   = ren_tag_i;
        end
        // Flush discards every mapping, including one made this cycle
        if (flush_i)
            st_d.valid = 1'b1;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q.valid <= 1'b1;
            st_q.tag   <= '0;
            st_q.value <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign valid_o = st_q.valid;
    assign tag_o   = st_q.tag;
    assign value_o = st_q.value;

    assert_rename_pends_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ren_hit_i && !flush_i) |=> (!valid_o && tag_o == $past(ren_tag_i)));

    assert_match_commit_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (com_hit_i && !ren_hit_i && !flush_i && !valid_o && tag_o == com_tag_i)
        |=> (valid_o && value_o == $past(com_value_i)));

    assert_stale_commit_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (com_hit_i && !ren_hit_i && !flush_i && !valid_o && tag_o != com_tag_i)
        |=> (!valid_o && $stable(tag_o) && value_o == $past(com_value_i)));

    assert_rename_beats_commit_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (com_hit_i && ren_hit_i && !flush_i)
        |=> (!valid_o && value_o == $past(com_value_i) && tag_o == $past(ren_tag_i)));

    assert_flush_ready_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        flush_i |=> valid_o);
endmodule

// File: rtl/rt_read_port.sv
// Indexed lookup into the table state (no associative search).
module rt_read_port #(
    parameter int NUM_REGS = rt_pkg::DEF_NUM_REGS,
    parameter int DATA_W   = rt_pkg::DEF_DATA_W,
    parameter int TAG_W    = rt_pkg::DEF_TAG_W,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input  logic [NUM_REGS-1:0] valid_vec_i,
    input  logic [TAG_W-1:0]    tag_arr_i   [NUM_REGS],
    input  logic [DATA_W-1:0]   value_arr_i [NUM_REGS],
    input  logic [IDX_W-1:0]    idx_i,
    output logic                ready_o,
    output logic [TAG_W-1:0]    tag_o,
    output logic [DATA_W-1:0]   value_o
);
    always_comb begin
        ready_o = valid_vec_i[idx_i];
        tag_o   = tag_arr_i[idx_i];
        value_o = value_arr_i[idx_i];
    end
endmodule

// File: rtl/rename_table.sv
module rename_table #(
    parameter int NUM_REGS = rt_pkg::DEF_NUM_REGS,
    parameter int DATA_W   = rt_pkg::DEF_DATA_W,
    parameter int TAG_W    = rt_pkg::DEF_TAG_W,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              flush_i,
    input  logic [IDX_W-1:0]  src_a_idx_i,
    output logic              src_a_ready_o,
    output logic [DATA_W-1:0] src_a_value_o,
    output logic [TAG_W-1:0]  src_a_tag_o,
    input  logic [IDX_W-1:0]  src_b_idx_i,
    output logic              src_b_ready_o,
    output logic [DATA_W-1:0] src_b_value_o,
    output logic [TAG_W-1:0]  src_b_tag_o,
    input  logic              ren_en_i,
    input  logic [IDX_W-1:0]  ren_reg_i,
    input  logic [TAG_W-1:0]  ren_tag_i,
    input  logic              com_en_i,
    input  logic [IDX_W-1:0]  com_reg_i,
    input  logic [TAG_W-1:0]  com_tag_i,
    input  logic [DATA_W-1:0] com_value_i
);
    logic [NUM_REGS-1:0] valid_vec;
    logic [TAG_W-1:0]    tag_arr   [NUM_REGS];
    logic [DATA_W-1:0]   value_arr [NUM_REGS];

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        if (i == 0) begin : g_zero
            // Hard-wired zero register: never pending, never written
            assign valid_vec[i] = 1'b1;
            assign tag_arr[i]   = '0;
            assign value_arr[i] = '0;
        end else begin : g_ren
            logic ren_hit, com_hit;
            assign ren_hit = ren_en_i && (ren_reg_i == IDX_W'(i));
            assign com_hit = com_en_i && (com_reg_i == IDX_W'(i));
            rt_entry #(.DATA_W(DATA_W), .TAG_W(TAG_W)) entry_i (
                .clk_i       (clk_i),
                .rst_ni      (rst_ni),
                .flush_i     (flush_i),
                .ren_hit_i   (ren_hit),
                .ren_tag_i   (ren_tag_i),
                .com_hit_i   (com_hit),
                .com_tag_i   (com_tag_i),
                .com_value_i (com_value_i),
                .valid_o     (valid_vec[i]),
                .tag_o       (tag_arr[i]),
                .value_o     (value_arr[i])
            );
        end
    end

    rt_read_port #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .TAG_W(TAG_W)) port_a_i (
        .valid_vec_i (valid_vec),
        .tag_arr_i   (tag_arr),
        .value_arr_i (value_arr),
        .idx_i       (src_a_idx_i),
        .ready_o     (src_a_ready_o),
        .tag_o       (src_a_tag_o),
        .value_o     (src_a_value_o)
    );

    rt_read_port #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .TAG_W(TAG_W)) port_b_i (
        .valid_vec_i (valid_vec),
        .tag_arr_i   (tag_arr),
        .value_arr_i (value_arr),
        .idx_i       (src_b_idx_i),
        .ready_o     (src_b_ready_o),
        .tag_o       (src_b_tag_o),
        .value_o     (src_b_value_o)
    );

    assert_zero_reg_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (src_a_idx_i == '0) |-> (src_a_ready_o && src_a_value_o == '0));

    assert_ports_agree_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (src_a_idx_i == src_b_idx_i) |-> (src_a_ready_o == src_b_ready_o &&
                                          src_a_value_o == src_b_value_o &&
                                          src_a_tag_o == src_b_tag_o));

    assert_hold_when_idle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!ren_en_i && !com_en_i && !flush_i) |=> $stable(valid_vec));
endmodule

// File: tb/rename_table_tb_top.sv
`timescale 1ns/1ps
module rename_table_tb_top;
    localparam int NR = 32;
    localparam int DW = 32;
    localparam int TW = 5;
    localparam int IW = 5;

    logic          clk = 1'b0;
    logic          rst_ni = 1'b0;
    logic          flush_i = 1'b0;
    logic [IW-1:0] src_a_idx_i = '0, src_b_idx_i = '0;
    logic          src_a_ready_o, src_b_ready_o;
    logic [DW-1:0] src_a_value_o, src_b_value_o;
    logic [TW-1:0] src_a_tag_o, src_b_tag_o;
    logic          ren_en_i = 1'b0, com_en_i = 1'b0;
    logic [IW-1:0] ren_reg_i = '0, com_reg_i = '0;
    logic [TW-1:0] ren_tag_i = '0, com_tag_i = '0;
    logic [DW-1:0] com_value_i = '0;

    always #4 clk = ~clk;  // 125 MHz

    rename_table dut_i (
        .clk_i(clk), .rst_ni(rst_ni), .flush_i(flush_i),
        .src_a_idx_i(src_a_idx_i), .src_a_ready_o(src_a_ready_o),
        .src_a_value_o(src_a_value_o), .src_a_tag_o(src_a_tag_o),
        .src_b_idx_i(src_b_idx_i), .src_b_ready_o(src_b_ready_o),
        .src_b_value_o(src_b_value_o), .src_b_tag_o(src_b_tag_o),
        .ren_en_i(ren_en_i), .ren_reg_i(ren_reg_i), .ren_tag_i(ren_tag_i),
        .com_en_i(com_en_i), .com_reg_i(com_reg_i), .com_tag_i(com_tag_i),
        .com_value_i(com_value_i)
    );

    typedef struct packed {
        logic          port_b;
        logic [IW-1:0] idx;
        logic          rdy;
        logic [TW-1:0] tag;
        logic [DW-1:0] val;
    } exp_t;

    exp_t  exp_q[$];
    string req_q[$];
    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done  = 1'b0;

    // Reference model written from the requirements
    logic          m_vld [NR];
    logic [TW-1:0] m_tag [NR];
    logic [DW-1:0] m_val [NR];

    task automatic push_exp(input logic pb, input logic [IW-1:0] idx, input string req);
        exp_t e;
        e.port_b = pb;
        e.idx    = idx;
        e.rdy    = m_vld[idx];
        e.tag    = m_tag[idx];
        e.val    = m_val[idx];
        exp_q.push_back(e);
        req_q.push_back(req);
    endtask

    task automatic model_update(input logic re, input logic [IW-1:0] rr, input logic [TW-1:0] rt,
                                input logic ce, input logic [IW-1:0] cr, input logic [TW-1:0] ct,
                                input logic [DW-1:0] cv, input logic fl);
        if (ce && cr != 0) begin
            m_val[cr] = cv;
            if (!m_vld[cr] && m_tag[cr] == ct) m_vld[cr] = 1'b1;
        end
        if (re && rr != 0 && !fl) begin
            m_vld[rr] = 1'b0;
            m_tag[rr] = rt;
        end
        if (fl) for (int i = 0; i < NR; i++) m_vld[i] = 1'b1;
    endtask

    // Driver: one cycle of stimulus, expectations from the pre-update model (R4)
    task automatic step(input logic re, input logic [IW-1:0] rr, input logic [TW-1:0] rt,
                        input logic ce, input logic [IW-1:0] cr, input logic [TW-1:0] ct,
                        input logic [DW-1:0] cv, input logic fl,
                        input logic [IW-1:0] ra, input logic [IW-1:0] rb, input string req);
        @(negedge clk);
        ren_en_i = re; ren_reg_i = rr; ren_tag_i = rt;
        com_en_i = ce; com_reg_i = cr; com_tag_i = ct; com_value_i = cv;
        flush_i = fl; src_a_idx_i = ra; src_b_idx_i = rb;
        push_exp(1'b0, ra, req);
        push_exp(1'b1, rb, req);
        model_update(re, rr, rt, ce, cr, ct, cv, fl);
    endtask

    task automatic look(input logic [IW-1:0] ra, input logic [IW-1:0] rb, input string req);
        step(1'b0, '0, '0, 1'b0, '0, '0, '0, 1'b0, ra, rb, req);
    endtask

    // Monitor: compare queued expectations against the lookup ports
    initial begin
        forever begin
            @(negedge clk);
            #3;
            while (exp_q.size() > 0) begin
                exp_t  e;
                string r;
                logic          g_rdy;
                logic [TW-1:0] g_tag;
                logic [DW-1:0] g_val;
                e = exp_q.pop_front();
                r = req_q.pop_front();
                g_rdy = e.port_b ? src_b_ready_o : src_a_ready_o;
                g_tag = e.port_b ? src_b_tag_o   : src_a_tag_o;
                g_val = e.port_b ? src_b_value_o : src_a_value_o;
                n_cmp++;
                if (g_rdy != e.rdy || g_val != e.val || (!e.rdy && g_tag != e.tag)) begin
                    n_bad++;
                    $display("FAIL %s reg %0d port %0d: got rdy=%0b tag=%0d val=%h, expected rdy=%0b tag=%0d val=%h",
                             r, e.idx, e.port_b, g_rdy, g_tag, g_val, e.rdy, e.tag, e.val);
                end
            end
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NR; i++) begin
            m_vld[i] = 1'b1; m_tag[i] = '0; m_val[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst_ni = 1'b1;

        // R1: every register ready and zero after reset
        for (int i = 0; i < NR; i += 2) look(IW'(i), IW'(i + 1), "R1");

        // R4: same-cycle lookup of the renamed register sees the old state
        step(1'b1, 5'd5, 5'd3, 1'b0, '0, '0, '0, 1'b0, 5'd5, 5'd6, "R4");
        // R3 and R5: pending with tag 3 on both ports
        look(5'd5, 5'd5, "R3");
        // R6: matching commit makes it ready
        step(1'b0, '0, '0, 1'b1, 5'd5, 5'd3, 32'hCAFE_0005, 1'b0, 5'd5, 5'd5, "R6");
        look(5'd5, 5'd0, "R6");

        // R7: two renames of r7, older producer commits first
        step(1'b1, 5'd7, 5'd4, 1'b0, '0, '0, '0, 1'b0, 5'd7, 5'd7, "R4");
        step(1'b1, 5'd7, 5'd9, 1'b0, '0, '0, '0, 1'b0, 5'd7, 5'd7, "R3");
        step(1'b0, '0, '0, 1'b1, 5'd7, 5'd4, 32'h0000_AAAA, 1'b0, 5'd7, 5'd7, "R3");
        look(5'd7, 5'd7, "R7");
        step(1'b0, '0, '0, 1'b1, 5'd7, 5'd9, 32'h0000_BBBB, 1'b0, 5'd7, 5'd7, "R7");
        look(5'd7, 5'd7, "R6");

        // R8: commit to an already ready register
        step(1'b0, '0, '0, 1'b1, 5'd10, 5'd0, 32'h1234_5678, 1'b0, 5'd10, 5'd10, "R8");
        look(5'd10, 5'd10, "R8");

        // R9: rename and commit to one register in the same cycle
        step(1'b1, 5'd12, 5'd1, 1'b0, '0, '0, '0, 1'b0, 5'd12, 5'd12, "R9");
        step(1'b1, 5'd12, 5'd2, 1'b1, 5'd12, 5'd1, 32'hDDDD_0012, 1'b0, 5'd12, 5'd12, "R9");
        look(5'd12, 5'd12, "R9");

        // R2: register 0 ignores rename and commit
        step(1'b1, 5'd0, 5'd5, 1'b1, 5'd0, 5'd0, 32'hFFFF_FFFF, 1'b0, 5'd0, 5'd0, "R2");
        look(5'd0, 5'd0, "R2");

        // R10: flush with a same-cycle rename and commit
        step(1'b1, 5'd3, 5'd6, 1'b0, '0, '0, '0, 1'b0, 5'd3, 5'd4, "R10");
        step(1'b1, 5'd4, 5'd7, 1'b0, '0, '0, '0, 1'b0, 5'd3, 5'd4, "R10");
        step(1'b1, 5'd8, 5'd11, 1'b1, 5'd3, 5'd6, 32'hEEEE_0003, 1'b1, 5'd3, 5'd4, "R10");
        look(5'd3, 5'd4, "R10");
        look(5'd8, 5'd12, "R10");

        // Random mix over all requirements (R3, R6, R7, R9 dominate)
        for (int n = 0; n < 2000; n++) begin
            logic [IW-1:0] rr, cr;
            logic [TW-1:0] ct;
            rr = IW'($urandom_range(0, 7));
            cr = IW'($urandom_range(0, 7));
            ct = ($urandom_range(0, 2) != 0) ? m_tag[cr] : TW'($urandom);
            step(1'($urandom_range(0, 1)), rr, TW'($urandom),
                 1'($urandom_range(0, 1)), cr, ct, DW'($urandom),
                 ($urandom_range(0, 40) == 0),
                 IW'($urandom_range(0, 7)), IW'($urandom_range(0, 7)), "R7");
        end
        look(5'd1, 5'd2, "R5");

        @(negedge clk);
        #5;
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule